// File: doc/BRIEF.md
# Posted Write Buffer

This block sits between a processor's store port and a bus master port. It takes stores that do not need to wait for the bus: stores to uncached regions that may be buffered, write-through stores and write misses to write-back regions. The processor moves on as soon as a store is accepted. A store to the word that directly follows the newest pending entry is folded into that entry, so a run of sequential stores leaves the block as one burst. A second, independent store holds one dirty cache line that is being evicted or cleaned, under a single base address.

Both stores drain through one bus master port, one word per accepted beat, with first and last markers and a source flag on each beat. At each burst boundary a full eviction store wins the port, which frees the cache to refill the line. A burst that has started always runs to its end. A drained flag shows when nothing is pending anywhere, so a barrier can wait on it. Addresses are word addresses.

Top module: `posted_write_buf`

## Requirements
- R1: After reset, st_ready and ev_ready are 1, bus_valid is 0 and drained is 1.
- R2: A store whose word address equals the newest pending entry's base plus its word count joins that entry. A run of such stores leaves as one burst of consecutive addresses, with bus_first=1 only on the first beat and bus_last=1 only on the last.
- R3: A store that is not the next sequential word opens a new address entry, and that entry leaves as a burst of its own.
- R4: While all ADDR_ENTRIES address entries (default 4) are in use, st_ready is 0 and a store offered meanwhile is not taken.
- R5: While all DATA_SLOTS data words (default 16) are in use, st_ready is 0.
- R6: Main-store entries leave in arrival order, and each beat carries the data of the store made to that address.
- R7: Once the first beat of the only pending entry has been accepted, a following sequential store is not folded into it. It opens a new entry, which then leaves as its own burst.
- R8: An accepted line on ev_valid/ev_ready drops ev_ready to 0 until the line has drained. The line leaves as LINE_WORDS beats (default 8) at base, base+1, and so on, with bus_src=1. bus_src=0 marks main-store beats.
- R9: When a line and main entries are both waiting at a burst boundary, the line's burst goes first. A burst in progress is never cut by the other source.
- R10: drained is 1 exactly when no main entry and no line are held.
- R11: While bus_valid=1 and bus_ready=0, bus_valid, bus_addr and bus_data hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| st_valid | input | 1 | Store offered |
| st_addr | input | AW | Store word address |
| st_data | input | DW | Store data |
| st_ready | output | 1 | Store accepted this cycle when high with st_valid |
| ev_valid | input | 1 | Eviction line offered |
| ev_addr | input | AW | Base word address of the line |
| ev_line | input | LINE_WORDS*DW | Line data, word i in bits i*DW upward |
| ev_ready | output | 1 | Eviction store is empty |
| bus_valid | output | 1 | Beat presented on the bus |
| bus_ready | input | 1 | Bus accepts the beat |
| bus_addr | output | AW | Beat word address |
| bus_data | output | DW | Beat data |
| bus_first | output | 1 | First beat of a burst |
| bus_last | output | 1 | Last beat of a burst (valid on the accepted beat) |
| bus_src | output | 1 | 1 for the eviction line, 0 for main stores |
| drained | output | 1 | Both stores empty |

## Verification
Some properties are checked on every cycle: beats stay stable while the bus stalls, addresses rise by one inside a burst, the source never changes mid-burst, the stall follows a full entry or data count, the eviction store takes one line at a time, and drained excludes bus activity. Other behaviour only the directed scenarios can show, because it needs whole store sequences to compare against. This covers the merge versus new-entry decision, the freeze on an entry under drain, arrival order and data integrity, the priority choice when both sources wait, and the fact that a stalled store is dropped rather than queued.

// File: rtl/pwb_pkg.sv
package pwb_pkg;
  // Which source currently owns the bus master port.
  typedef enum logic [1:0] {
    OWN_IDLE  = 2'd0,
    OWN_MAIN  = 2'd1,
    OWN_EVICT = 2'd2
  } owner_e;
endpackage

// File: rtl/pwb_main_fifo.sv
// Main store: address entries (base + word count) over a shared data ring.
// ENTRIES >= 2 and SLOTS >= 2 required.
module pwb_main_fifo #(
  parameter int AW      = 32,
  parameter int DW      = 32,
  parameter int ENTRIES = 4,
  parameter int SLOTS   = 16,
  localparam int EW  = $clog2(ENTRIES),
  localparam int ECW = $clog2(ENTRIES + 1),
  localparam int SW  = $clog2(SLOTS),
  localparam int LW  = $clog2(SLOTS + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           push,
  input  logic [AW-1:0]  push_addr,
  input  logic [DW-1:0]  push_data,
  input  logic           lock_newest,
  input  logic           pop_word,
  input  logic           pop_entry,
  output logic           can_accept,
  output logic [AW-1:0]  head_base,
  output logic [LW-1:0]  head_len,
  output logic [DW-1:0]  head_data,
  output logic [ECW-1:0] ent_cnt,
  output logic [LW-1:0]  word_cnt
);
  logic [AW-1:0]  base_q [ENTRIES];
  logic [LW-1:0]  len_q  [ENTRIES];
  logic [DW-1:0]  data_q [SLOTS];

  logic [EW-1:0]  ewr_q, ewr_d, erd_q, erd_d, newest;
  logic [ECW-1:0] ecnt_q, ecnt_d;
  logic [SW-1:0]  dwr_q, dwr_d, drd_q, drd_d;
  logic [LW-1:0]  dcnt_q, dcnt_d;
  logic           merge, new_ent;

  always_comb begin
    newest  = (ewr_q == '0) ? EW'(ENTRIES - 1) : ewr_q - EW'(1);
    merge   = push && (ecnt_q != '0) && !lock_newest &&
              (push_addr == base_q[newest] + AW'(len_q[newest]));
    new_ent = push && !merge;

    ewr_d  = new_ent   ? ((ewr_q == EW'(ENTRIES - 1)) ? '0 : ewr_q + EW'(1)) : ewr_q;
    erd_d  = pop_entry ? ((erd_q == EW'(ENTRIES - 1)) ? '0 : erd_q + EW'(1)) : erd_q;
    ecnt_d = ecnt_q + ECW'(new_ent) - ECW'(pop_entry);
    dwr_d  = push      ? ((dwr_q == SW'(SLOTS - 1)) ? '0 : dwr_q + SW'(1)) : dwr_q;
    drd_d  = pop_word  ? ((drd_q == SW'(SLOTS - 1)) ? '0 : drd_q + SW'(1)) : drd_q;
    dcnt_d = dcnt_q + LW'(push) - LW'(pop_word);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ewr_q  <= '0;
      erd_q  <= '0;
      ecnt_q <= '0;
      dwr_q  <= '0;
      drd_q  <= '0;
      dcnt_q <= '0;
    end else begin
      ewr_q  <= ewr_d;
      erd_q  <= erd_d;
      ecnt_q <= ecnt_d;
      dwr_q  <= dwr_d;
      drd_q  <= drd_d;
      dcnt_q <= dcnt_d;
    end
  end

  // Storage arrays carry no reset; counters guard their contents.
  always_ff @(posedge clk) begin
    if (new_ent) begin
      base_q[ewr_q] <= push_addr;
      len_q[ewr_q]  <= LW'(1);
    end
    if (merge) begin
      len_q[newest] <= len_q[newest] + LW'(1);
    end
    if (push) begin
      data_q[dwr_q] <= push_data;
    end
  end

  assign can_accept = (ecnt_q != ECW'(ENTRIES)) && (dcnt_q != LW'(SLOTS));
  assign head_base  = base_q[erd_q];
  assign head_len   = len_q[erd_q];
  assign head_data  = data_q[drd_q];
  assign ent_cnt    = ecnt_q;
  assign word_cnt   = dcnt_q;
endmodule

// File: rtl/pwb_evict_buf.sv
// Single-line eviction store: one base address, WORDS data words.
module pwb_evict_buf #(
  parameter int AW    = 32,
  parameter int DW    = 32,
  parameter int WORDS = 8,
  localparam int BW = $clog2(WORDS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                load,
  input  logic [AW-1:0]       ld_addr,
  input  logic [WORDS*DW-1:0] ld_line,
  input  logic [BW-1:0]       beat,
  input  logic                pop,
  output logic                full,
  output logic [AW-1:0]       base,
  output logic [DW-1:0]       word
);
  logic                full_q, full_d;
  logic [AW-1:0]       base_q;
  logic [DW-1:0]       line_q [WORDS];

  always_comb begin
    full_d = full_q;
    if (pop)  full_d = 1'b0;
    if (load) full_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) full_q <= 1'b0;
    else        full_q <= full_d;
  end

  always_ff @(posedge clk) begin
    if (load) base_q <= ld_addr;
  end

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    always_ff @(posedge clk) begin
      if (load) line_q[g] <= ld_line[g*DW +: DW];
    end
  end

  assign full = full_q;
  assign base = base_q;
  assign word = line_q[beat];
endmodule

// File: rtl/pwb_drain_arb.sv
// Bus owner selection at burst boundaries and the beat counter.
module pwb_drain_arb
  import pwb_pkg::*;
#(
  parameter int LW    = 5,
  parameter int BW    = 4,
  parameter int WORDS = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          main_pend,
  input  logic          ev_full,
  input  logic [LW-1:0] head_len,
  input  logic          bus_ready,
  output owner_e        owner,
  output logic [BW-1:0] beat,
  output logic          bus_valid,
  output logic          bus_last,
  output logic          main_pop_word,
  output logic          main_pop_entry,
  output logic          ev_pop
);
  owner_e        own_q, own_d;
  logic [BW-1:0] beat_q, beat_d;
  logic          fire, last;

  always_comb begin
    bus_valid = (own_q != OWN_IDLE);
    fire      = bus_valid && bus_ready;
    if (own_q == OWN_EVICT) last = (32'(beat_q) + 32'd1 == 32'(WORDS));
    else                    last = (32'(beat_q) + 32'd1 == 32'(head_len));

    own_d  = own_q;
    beat_d = beat_q;
    if (own_q == OWN_IDLE) begin
      if (ev_full)        own_d = OWN_EVICT;
      else if (main_pend) own_d = OWN_MAIN;
    end else if (fire) begin
      if (last) begin
        own_d  = OWN_IDLE;
        beat_d = '0;
      end else begin
        beat_d = beat_q + BW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      own_q  <= OWN_IDLE;
      beat_q <= '0;
    end else begin
      own_q  <= own_d;
      beat_q <= beat_d;
    end
  end

  assign owner          = own_q;
  assign beat           = beat_q;
  assign bus_last       = last;
  assign main_pop_word  = fire && (own_q == OWN_MAIN);
  assign main_pop_entry = fire && (own_q == OWN_MAIN) && last;
  assign ev_pop         = fire && (own_q == OWN_EVICT) && last;
endmodule

// File: rtl/posted_write_buf.sv
module posted_write_buf
  import pwb_pkg::*;
#(
  parameter int AW           = 32,
  parameter int DW           = 32,
  parameter int ADDR_ENTRIES = 4,
  parameter int DATA_SLOTS   = 16,
  parameter int LINE_WORDS   = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     st_valid,
  input  logic [AW-1:0]            st_addr,
  input  logic [DW-1:0]            st_data,
  output logic                     st_ready,
  input  logic                     ev_valid,
  input  logic [AW-1:0]            ev_addr,
  input  logic [LINE_WORDS*DW-1:0] ev_line,
  output logic                     ev_ready,
  output logic                     bus_valid,
  input  logic                     bus_ready,
  output logic [AW-1:0]            bus_addr,
  output logic [DW-1:0]            bus_data,
  output logic                     bus_first,
  output logic                     bus_last,
  output logic                     bus_src,
  output logic                     drained
);
  localparam int ECW  = $clog2(ADDR_ENTRIES + 1);
  localparam int LW   = $clog2(DATA_SLOTS + 1);
  localparam int EBW  = $clog2(LINE_WORDS);
  localparam int MAXB = (DATA_SLOTS > LINE_WORDS) ? DATA_SLOTS : LINE_WORDS;
  localparam int BW   = $clog2(MAXB);

  owner_e         owner;
  logic [BW-1:0]  beat;
  logic           can_accept, lock_newest, st_fire, ev_fire;
  logic           pop_word, pop_entry, ev_pop, ev_full;
  logic [AW-1:0]  head_base, ev_base;
  logic [LW-1:0]  head_len, word_cnt;
  logic [DW-1:0]  head_data, ev_word;
  logic [ECW-1:0] ent_cnt;

  assign st_ready = can_accept;
  assign st_fire  = st_valid && can_accept;
  assign ev_ready = !ev_full;
  assign ev_fire  = ev_valid && !ev_full;

  // The head entry's length freezes once its first beat is taken.
  assign lock_newest = (owner == OWN_MAIN) && (ent_cnt == ECW'(1)) &&
                       ((beat != '0) || bus_ready);

  pwb_main_fifo #(
    .AW(AW), .DW(DW), .ENTRIES(ADDR_ENTRIES), .SLOTS(DATA_SLOTS)
  ) u_main (
    .clk(clk), .rst_n(rst_n),
    .push(st_fire), .push_addr(st_addr), .push_data(st_data),
    .lock_newest(lock_newest), .pop_word(pop_word), .pop_entry(pop_entry),
    .can_accept(can_accept), .head_base(head_base), .head_len(head_len),
    .head_data(head_data), .ent_cnt(ent_cnt), .word_cnt(word_cnt)
  );

  pwb_evict_buf #(
    .AW(AW), .DW(DW), .WORDS(LINE_WORDS)
  ) u_evict (
    .clk(clk), .rst_n(rst_n),
    .load(ev_fire), .ld_addr(ev_addr), .ld_line(ev_line),
    .beat(beat[EBW-1:0]), .pop(ev_pop),
    .full(ev_full), .base(ev_base), .word(ev_word)
  );

  pwb_drain_arb #(
    .LW(LW), .BW(BW), .WORDS(LINE_WORDS)
  ) u_arb (
    .clk(clk), .rst_n(rst_n),
    .main_pend(ent_cnt != '0), .ev_full(ev_full), .head_len(head_len),
    .bus_ready(bus_ready), .owner(owner), .beat(beat),
    .bus_valid(bus_valid), .bus_last(bus_last),
    .main_pop_word(pop_word), .main_pop_entry(pop_entry), .ev_pop(ev_pop)
  );

  always_comb begin
    if (owner == OWN_EVICT) begin
      bus_addr = ev_base + AW'(beat);
      bus_data = ev_word;
    end else begin
      bus_addr = head_base + AW'(beat);
      bus_data = head_data;
    end
  end

  assign bus_first = (beat == '0);
  assign bus_src   = (owner == OWN_EVICT);
  assign drained   = (ent_cnt == '0) && !ev_full;
endmodule

// File: rtl/pwb_checker.sv
module pwb_checker #(
  parameter int AW           = 32,
  parameter int ADDR_ENTRIES = 4,
  parameter int DATA_SLOTS   = 16,
  localparam int ECW = $clog2(ADDR_ENTRIES + 1),
  localparam int LW  = $clog2(DATA_SLOTS + 1)
) (
  input logic           clk,
  input logic           rst_n,
  input logic           st_ready,
  input logic           ev_valid,
  input logic           ev_ready,
  input logic           bus_valid,
  input logic           bus_ready,
  input logic [AW-1:0]  bus_addr,
  input logic [31:0]    bus_data_lo,
  input logic           bus_last,
  input logic           bus_src,
  input logic           drained,
  input logic [ECW-1:0] ent_cnt,
  input logic [LW-1:0]  word_cnt
);
  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_data_lo)); // R11
  AST_BURST_INCR: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_ready && !bus_last |=> bus_valid && (bus_addr == $past(bus_addr) + AW'(1))); // R2
  AST_NO_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_valid && bus_ready && !bus_last |=> $stable(bus_src)); // R9
  AST_ENTRY_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_cnt == ECW'(ADDR_ENTRIES)) |-> !st_ready); // R4
  AST_SLOT_STALL: assert property (@(posedge clk) disable iff (!rst_n)
    (word_cnt == LW'(DATA_SLOTS)) |-> !st_ready); // R5
  AST_ONE_LINE: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid && ev_ready |=> !ev_ready); // R8
  AST_DRAINED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    drained |-> !bus_valid); // R10
endmodule

bind posted_write_buf pwb_checker #(
  .AW(AW), .ADDR_ENTRIES(ADDR_ENTRIES), .DATA_SLOTS(DATA_SLOTS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .st_ready(st_ready), .ev_valid(ev_valid),
  .ev_ready(ev_ready), .bus_valid(bus_valid), .bus_ready(bus_ready),
  .bus_addr(bus_addr), .bus_data_lo(32'(bus_data)), .bus_last(bus_last),
  .bus_src(bus_src), .drained(drained), .ent_cnt(ent_cnt), .word_cnt(word_cnt)
);

// File: tb/posted_write_buf_tb.sv
module posted_write_buf_tb;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         st_valid, st_ready, ev_valid, ev_ready;
  logic [31:0]  st_addr, st_data, ev_addr;
  logic [255:0] ev_line;
  logic         bus_valid, bus_ready, bus_first, bus_last, bus_src, drained;
  logic [31:0]  bus_addr, bus_data;

  int checks = 0;
  int errors = 0;

  logic [31:0] m_addr [64];
  logic [31:0] m_data [64];
  logic [2:0]  m_flag [64];
  int          mon_n = 0;

  always #5 clk = ~clk;

  posted_write_buf u_dut (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_addr(st_addr),
    .st_data(st_data), .st_ready(st_ready), .ev_valid(ev_valid),
    .ev_addr(ev_addr), .ev_line(ev_line), .ev_ready(ev_ready),
    .bus_valid(bus_valid), .bus_ready(bus_ready), .bus_addr(bus_addr),
    .bus_data(bus_data), .bus_first(bus_first), .bus_last(bus_last),
    .bus_src(bus_src), .drained(drained)
  );

  // Beat recorder: inputs change just after posedge, so negedge is quiet.
  always @(negedge clk) begin
    if (rst_n && bus_valid && bus_ready && mon_n < 64) begin
      m_addr[mon_n] = bus_addr;
      m_data[mon_n] = bus_data;
      m_flag[mon_n] = {bus_first, bus_last, bus_src};
      mon_n = mon_n + 1;
    end
  end

  function automatic logic [31:0] sdat(input logic [31:0] a);
    return a ^ 32'h5A5A_0000;
  endfunction

  function automatic logic [31:0] edat(input logic [31:0] base, input int i);
    return 32'hE000_0000 ^ (base << 4) ^ 32'(i);
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic exp_beat(input int i, input logic [31:0] a, input logic [31:0] d,
                          input bit f, input bit l, input bit s, input string req);
    logic [66:0] act, exp;
    act = (i < mon_n) ? {m_addr[i], m_data[i], m_flag[i]} : '1;
    exp = {a, d, f, l, s};
    chk(act == exp, req, $sformatf("beat %0d {addr,data,first,last,src}", i), 128'(act), 128'(exp));
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic store(input logic [31:0] a);
    st_valid = 1'b1;
    st_addr  = a;
    st_data  = sdat(a);
    do @(negedge clk); while (!st_ready);
    tick();
    st_valid = 1'b0;
  endtask

  task automatic load_line(input logic [31:0] base);
    ev_valid = 1'b1;
    ev_addr  = base;
    for (int i = 0; i < 8; i++) ev_line[i*32 +: 32] = edat(base, i);
    do @(negedge clk); while (!ev_ready);
    tick();
    ev_valid = 1'b0;
  endtask

  task automatic drain_all(input string req);
    bus_ready = 1'b1;
    for (int i = 0; i < 300; i++) begin
      @(negedge clk);
      if (drained) break;
    end
    chk(drained == 1'b1, req, "drained after release", 128'(drained), 128'(1));
    tick();
    bus_ready = 1'b0;
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk({st_ready, ev_ready, bus_valid, drained} == 4'b1101, "R1",
        "reset {st_ready,ev_ready,bus_valid,drained}",
        128'({st_ready, ev_ready, bus_valid, drained}), 128'(4'b1101));
    tick();
  endtask

  task automatic t_merge();
    mon_n = 0;
    for (int i = 0; i < 4; i++) store(32'h100 + 32'(i));
    @(negedge clk);
    chk(drained == 1'b0, "R10", "drained with pending stores", 128'(drained), 128'(0));
    tick();
    drain_all("R2");
    chk(mon_n == 4, "R2", "beat count merged run", 128'(mon_n), 128'(4));
    for (int i = 0; i < 4; i++)
      exp_beat(i, 32'h100 + 32'(i), sdat(32'h100 + 32'(i)), i == 0, i == 3, 1'b0, "R2");
  endtask

  task automatic t_separate();
    mon_n = 0;
    store(32'h200); store(32'h201); store(32'h300); store(32'h210);
    drain_all("R3");
    chk(mon_n == 4, "R3", "beat count", 128'(mon_n), 128'(4));
    exp_beat(0, 32'h200, sdat(32'h200), 1, 0, 0, "R6");
    exp_beat(1, 32'h201, sdat(32'h201), 0, 1, 0, "R6");
    exp_beat(2, 32'h300, sdat(32'h300), 1, 1, 0, "R3");
    exp_beat(3, 32'h210, sdat(32'h210), 1, 1, 0, "R3");
  endtask

  task automatic t_entry_full();
    mon_n = 0;
    store(32'h400); store(32'h500); store(32'h600); store(32'h700);
    st_valid = 1'b1; st_addr = 32'h480; st_data = sdat(32'h480);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk(st_ready == 1'b0, "R4", "st_ready with all entries used", 128'(st_ready), 128'(0));
      tick();
    end
    st_valid = 1'b0;
    drain_all("R4");
    chk(mon_n == 4, "R4", "stalled store not taken, beat count", 128'(mon_n), 128'(4));
    exp_beat(0, 32'h400, sdat(32'h400), 1, 1, 0, "R6");
    exp_beat(1, 32'h500, sdat(32'h500), 1, 1, 0, "R6");
    exp_beat(2, 32'h600, sdat(32'h600), 1, 1, 0, "R6");
    exp_beat(3, 32'h700, sdat(32'h700), 1, 1, 0, "R6");
  endtask

  task automatic t_slot_full();
    mon_n = 0;
    for (int i = 0; i < 16; i++) store(32'h1000 + 32'(i));
    @(negedge clk);
    chk(st_ready == 1'b0, "R5", "st_ready with all data slots used", 128'(st_ready), 128'(0));
    tick();
    drain_all("R5");
    chk(mon_n == 16, "R5", "beat count", 128'(mon_n), 128'(16));
    exp_beat(0, 32'h1000, sdat(32'h1000), 1, 0, 0, "R5");
    exp_beat(7, 32'h1007, sdat(32'h1007), 0, 0, 0, "R5");
    exp_beat(15, 32'h100F, sdat(32'h100F), 0, 1, 0, "R5");
  endtask

  task automatic t_hold();
    logic [31:0] a0, d0;
    mon_n = 0;
    store(32'h1500); store(32'h1501);
    tick(); tick();
    @(negedge clk);
    a0 = bus_addr; d0 = bus_data;
    chk(bus_valid == 1'b1, "R11", "bus_valid while stalled", 128'(bus_valid), 128'(1));
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk({bus_valid, bus_addr, bus_data} == {1'b1, a0, d0}, "R11", "held beat",
          128'({bus_valid, bus_addr, bus_data}), 128'({1'b1, a0, d0}));
    end
    tick();
    drain_all("R11");
    exp_beat(0, 32'h1500, sdat(32'h1500), 1, 0, 0, "R11");
  endtask

  task automatic t_lock();
    mon_n = 0;
    store(32'h2000); store(32'h2001);
    tick(); tick();
    bus_ready = 1'b1;
    tick();
    bus_ready = 1'b0;
    store(32'h2002);
    drain_all("R7");
    chk(mon_n == 3, "R7", "beat count", 128'(mon_n), 128'(3));
    exp_beat(0, 32'h2000, sdat(32'h2000), 1, 0, 0, "R7");
    exp_beat(1, 32'h2001, sdat(32'h2001), 0, 1, 0, "R7");
    exp_beat(2, 32'h2002, sdat(32'h2002), 1, 1, 0, "R7");
  endtask

  task automatic t_evict();
    mon_n = 0;
    load_line(32'h3000);
    @(negedge clk);
    chk(ev_ready == 1'b0, "R8", "ev_ready while line held", 128'(ev_ready), 128'(0));
    chk(drained == 1'b0, "R10", "drained with line held", 128'(drained), 128'(0));
    tick();
    drain_all("R8");
    chk(mon_n == 8, "R8", "line beat count", 128'(mon_n), 128'(8));
    for (int i = 0; i < 8; i++)
      exp_beat(i, 32'h3000 + 32'(i), edat(32'h3000, i), i == 0, i == 7, 1'b1, "R8");
    @(negedge clk);
    chk(ev_ready == 1'b1, "R8", "ev_ready after line drained", 128'(ev_ready), 128'(1));
    tick();
  endtask

  task automatic t_priority();
    mon_n = 0;
    st_valid = 1'b1; st_addr = 32'h4000; st_data = sdat(32'h4000);
    ev_valid = 1'b1; ev_addr = 32'h6000;
    for (int i = 0; i < 8; i++) ev_line[i*32 +: 32] = edat(32'h6000, i);
    tick();
    st_valid = 1'b0; ev_valid = 1'b0;
    tick();
    drain_all("R9");
    chk(mon_n == 9, "R9", "beat count", 128'(mon_n), 128'(9));
    exp_beat(0, 32'h6000, edat(32'h6000, 0), 1, 0, 1, "R9");
    exp_beat(7, 32'h6007, edat(32'h6000, 7), 0, 1, 1, "R9");
    exp_beat(8, 32'h4000, sdat(32'h4000), 1, 1, 0, "R9");
  endtask

  task automatic t_no_preempt();
    mon_n = 0;
    store(32'h5000); store(32'h5001); store(32'h5002);
    tick();
    bus_ready = 1'b1;
    tick();
    bus_ready = 1'b0;
    load_line(32'h7000);
    drain_all("R9");
    chk(mon_n == 11, "R9", "beat count", 128'(mon_n), 128'(11));
    exp_beat(0, 32'h5000, sdat(32'h5000), 1, 0, 0, "R9");
    exp_beat(2, 32'h5002, sdat(32'h5002), 0, 1, 0, "R9");
    exp_beat(3, 32'h7000, edat(32'h7000, 0), 1, 0, 1, "R9");
    exp_beat(10, 32'h7007, edat(32'h7000, 7), 0, 1, 1, "R9");
  endtask

  initial begin
    rst_n = 1'b0; st_valid = 1'b0; st_addr = '0; st_data = '0;
    ev_valid = 1'b0; ev_addr = '0; ev_line = '0; bus_ready = 1'b0;
    repeat (3) @(posedge clk);
    t_reset();
    #1 rst_n = 1'b1;
    tick();
    t_reset();
    t_merge();
    t_separate();
    t_entry_full();
    t_slot_full();
    t_hold();
    t_lock();
    t_evict();
    t_priority();
    t_no_preempt();
    @(negedge clk);
    chk(drained == 1'b1, "R10", "drained at end", 128'(drained), 128'(1));
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule